// File: doc/BRIEF.md
# NOR Flash Warm Reset Sequencer

This block drives the hardware reset line of a parallel NOR flash when the surrounding system asks for a warm reset while the supplies are stable. It drives the reset line low for a fixed number of clocks. It then keeps the flash control strobes parked inactive until the device can take commands again. The caller says whether a program or erase may have been running when the request was made. That flag matters because an interrupted embedded operation needs a longer recovery, counted from the falling edge of reset.

Three recovery policies are offered. The fixed-delay policy counts clocks: a short wait after reset when the device was idle, and a longer wait when an operation may have been running. The ready-polling policy watches the ready/busy pin through a two-flop synchronizer and ends the recovery as soon as the pin reads ready. A timeout covers the case where the pin never goes high; it raises an error flag and still finishes. The uniform policy uses one wait length whatever the operation flag says, chosen so that reset-low time plus the following wait covers the minimum reset-to-access time.

The controller is a four-state machine. The states are IDLE (done, accepting requests), PULSE (reset line low), WAIT (counted recovery) and POLL (waiting for ready). The transitions are:
- IDLE to PULSE when a request is sampled.
- PULSE to WAIT or to POLL, depending on the latched policy, when the pulse count expires.
- WAIT to IDLE when the recovery count expires.
- POLL to IDLE either on a synchronized ready or on the timeout.

Top module: `nor_warm_rst_ctrl`

## Requirements
- R1: After controller reset, `flash_rst_n_o` is 1, `ctl_hold_o` is 0, `done_o` is 1 and `err_o` is 0.
- R2: A request sampled high at a clock edge while idle drives `flash_rst_n_o` low from the next cycle, for exactly PULSE_CYC cycles, in every policy.
- R3: Fixed-delay policy (`mode_i` = 2'b00) with `op_busy_i` = 0: `ctl_hold_o` stays high for PULSE_CYC + HOLD_CYC cycles in total.
- R4: Fixed-delay policy with `op_busy_i` = 1: `ctl_hold_o` stays high for max(READY_CYC, PULSE_CYC + HOLD_CYC) cycles, counted from the first cycle with reset low.
- R5: Uniform policy (`mode_i` = 2'b10 or 2'b11): `ctl_hold_o` stays high for PULSE_CYC + max(HOLD_CYC, RPH_CYC - PULSE_CYC) cycles, whatever the value of `op_busy_i`.
- R6: Ready-polling policy (`mode_i` = 2'b01): after the pulse, the block waits for `rdy_pin_i` = 1 (1 means ready). When that input rises between edges E+D and E+D+1, where E is the edge that released reset, `ctl_hold_o` falls after edge E+D+3, because of the two synchronizer flops. `err_o` stays 0.
- R7: Ready-polling policy with `rdy_pin_i` held at 0: the wait ends after POLL_TO_CYC cycles in the polling state, and `err_o` goes to 1 as `done_o` returns.
- R8: `ctl_hold_o` is 1 in every cycle in which `flash_rst_n_o` is 0. `done_o` is 1 exactly when `ctl_hold_o` is 0.
- R9: A request made while a sequence is running has no effect: it neither lengthens nor repeats the sequence.
- R10: `err_o` holds its value until the next request is accepted, and is cleared at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous controller reset |
| req_i | input | 1 | Warm reset request, sampled while idle |
| op_busy_i | input | 1 | A program or erase may be running; latched with the request |
| rdy_pin_i | input | 1 | Flash ready/busy pin, asynchronous, 1 = ready |
| mode_i | input | 2 | 00 fixed delay, 01 ready polling, 1x uniform delay; latched with the request |
| flash_rst_n_o | output | 1 | Flash hardware reset line, active low |
| ctl_hold_o | output | 1 | Forces chip, output and write enables inactive |
| done_o | output | 1 | Sequence finished; flash may be accessed |
| err_o | output | 1 | Last polling sequence timed out |

## Verification
The bench measures, at the ports, the exact length of the reset-low window and of the hold window for every policy and both values of the operation flag.
- If the operation flag were ignored in fixed mode, or wrongly used in uniform mode, the hold length would come out wrong.
- In polling, the bench releases ready at a known offset. A synchronizer with the wrong depth moves the release by a cycle.
- A timeout counter that is off by one shows up as a 71- or 73-cycle hold instead of 72.
- The bench repeats a request in the middle of a sequence. A design that restarted would stretch the window or queue an extra one.
- A sticky error that is never cleared, or one that is cleared too early, is caught by checks on either side of the next request.

// File: rtl/nwr_pkg.sv
package nwr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_POLL  = 2'd3
    } nwr_state_e;

    typedef enum logic [1:0] {
        POL_FIXED = 2'd0,
        POL_POLL  = 2'd1,
        POL_UNI   = 2'd2
    } nwr_policy_e;

    function automatic int unsigned nwr_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nwr_sync.sv
module nwr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/nwr_timer.sv
module nwr_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R9
    timer_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/nor_warm_rst_ctrl.sv
module nor_warm_rst_ctrl
    import nwr_pkg::*;
#(
    parameter int PULSE_CYC   = 8,
    parameter int HOLD_CYC    = 4,
    parameter int READY_CYC   = 20,
    parameter int RPH_CYC     = 16,
    parameter int POLL_TO_CYC = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       op_busy_i,
    input  logic       rdy_pin_i,
    input  logic [1:0] mode_i,
    output logic       flash_rst_n_o,
    output logic       ctl_hold_o,
    output logic       done_o,
    output logic       err_o
);
    localparam int WAIT_IDLE_OP = nwr_max(HOLD_CYC, 1);
    localparam int WAIT_BUSY_OP = nwr_max(nwr_max(HOLD_CYC, READY_CYC - PULSE_CYC), 1);
    localparam int WAIT_UNI     = nwr_max(nwr_max(HOLD_CYC, RPH_CYC - PULSE_CYC), 1);
    localparam int CNT_MAX      = nwr_max(nwr_max(PULSE_CYC, POLL_TO_CYC),
                                          nwr_max(WAIT_BUSY_OP, WAIT_UNI));
    localparam int CNT_W        = $clog2(CNT_MAX + 1);

    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_IDLE  = CNT_W'(WAIT_IDLE_OP - 1);
    localparam logic [CNT_W-1:0] LD_BUSY  = CNT_W'(WAIT_BUSY_OP - 1);
    localparam logic [CNT_W-1:0] LD_UNI   = CNT_W'(WAIT_UNI - 1);
    localparam logic [CNT_W-1:0] LD_POLL  = CNT_W'(POLL_TO_CYC - 1);

    nwr_state_e  st_q, st_d;
    nwr_policy_e pol_q, pol_req;
    logic        op_q;
    logic        err_q, err_set, err_clr;
    logic        rdy_s;
    logic        tm_load, tm_dec, tm_zero;
    logic [CNT_W-1:0] tm_val;

    nwr_sync #(.STAGES(2)) u_rdy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rdy_pin_i),
        .q_o   (rdy_s)
    );

    nwr_timer #(.W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tm_load),
        .load_val_i (tm_val),
        .dec_i      (tm_dec),
        .zero_o     (tm_zero)
    );

    always_comb begin
        if (mode_i[1]) begin
            pol_req = POL_UNI;
        end else if (mode_i[0]) begin
            pol_req = POL_POLL;
        end else begin
            pol_req = POL_FIXED;
        end
    end

    // next-state and timer control
    always_comb begin
        st_d    = st_q;
        tm_load = 1'b0;
        tm_dec  = 1'b0;
        tm_val  = LD_PULSE;
        err_set = 1'b0;
        err_clr = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_i) begin
                    st_d    = ST_PULSE;
                    tm_load = 1'b1;
                    tm_val  = LD_PULSE;
                    err_clr = 1'b1;
                end
            end
            ST_PULSE: begin
                if (tm_zero) begin
                    tm_load = 1'b1;
                    if (pol_q == POL_POLL) begin
                        st_d   = ST_POLL;
                        tm_val = LD_POLL;
                    end else begin
                        st_d = ST_WAIT;
                        if (pol_q == POL_UNI) begin
                            tm_val = LD_UNI;
                        end else if (op_q) begin
                            tm_val = LD_BUSY;
                        end else begin
                            tm_val = LD_IDLE;
                        end
                    end
                end else begin
                    tm_dec = 1'b1;
                end
            end
            ST_WAIT: begin
                if (tm_zero) begin
                    st_d = ST_IDLE;
                end else begin
                    tm_dec = 1'b1;
                end
            end
            ST_POLL: begin
                if (rdy_s) begin
                    st_d = ST_IDLE;
                end else if (tm_zero) begin
                    st_d    = ST_IDLE;
                    err_set = 1'b1;
                end else begin
                    tm_dec = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register and request latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            pol_q <= POL_FIXED;
            op_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && req_i) begin
                pol_q <= pol_req;
                op_q  <= op_busy_i;
            end
            if (err_set) begin
                err_q <= 1'b1;
            end else if (err_clr) begin
                err_q <= 1'b0;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        flash_rst_n_o = 1'b1;
        ctl_hold_o    = 1'b1;
        done_o        = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                ctl_hold_o = 1'b0;
                done_o     = 1'b1;
            end
            ST_PULSE: flash_rst_n_o = 1'b0;
            ST_WAIT:  ;
            ST_POLL:  ;
            default:  ;
        endcase
        err_o = err_q;
    end

    // R8
    rst_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_rst_n_o |-> ctl_hold_o);

    // R2
    hold_starts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_hold_o) |-> !flash_rst_n_o);

    // R6
    poll_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_POLL && rdy_s) |=> (st_q == ST_IDLE && !err_q));

    // R7
    err_from_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> ($past(st_q) == ST_POLL && done_o));

    // R10
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && req_i) |=> !err_q);
endmodule

// File: tb/nor_warm_rst_ctrl_bench.sv
module nor_warm_rst_ctrl_bench;
    localparam int P_PULSE = 8;
    localparam int P_HOLD  = 4;
    localparam int P_READY = 20;
    localparam int P_RPH   = 16;
    localparam int P_TO    = 64;

    typedef struct {
        int    low;
        int    hold;
        logic  err;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic       op_busy_i = 1'b0;
    logic       rdy_pin_i = 1'b1;
    logic [1:0] mode_i = 2'b00;
    logic       flash_rst_n_o, ctl_hold_o, done_o, err_o;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;
    exp_t expq[$];

    always #2.5 clk = ~clk;

    nor_warm_rst_ctrl #(
        .PULSE_CYC(P_PULSE), .HOLD_CYC(P_HOLD), .READY_CYC(P_READY),
        .RPH_CYC(P_RPH), .POLL_TO_CYC(P_TO)
    ) u_nor_warm_rst_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_busy_i(op_busy_i),
        .rdy_pin_i(rdy_pin_i), .mode_i(mode_i), .flash_rst_n_o(flash_rst_n_o),
        .ctl_hold_o(ctl_hold_o), .done_o(done_o), .err_o(err_o)
    );

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: measures each hold window and compares to the scoreboard
    int low_len = 0, hold_len = 0, outside = 0;
    logic prev_hold = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ctl_hold_o) hold_len++;
            if (!flash_rst_n_o) low_len++;
            if (!flash_rst_n_o && !ctl_hold_o) outside++;
            if (prev_hold && !ctl_hold_o) begin
                if (expq.size() == 0) begin
                    check("R9 unexpected sequence", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check({e.tag, " R2 low length"}, low_len, e.low);
                    check({e.tag, " hold length"}, hold_len, e.hold);
                    check({e.tag, " R7 error flag"}, int'(err_o), int'(e.err));
                    check({e.tag, " R8 done at end"}, int'(done_o), 1);
                    check({e.tag, " R8 low outside hold"}, outside, 0);
                end
                low_len = 0; hold_len = 0; outside = 0;
            end
            prev_hold = ctl_hold_o;
        end
    end

    // driver: starts one sequence and pushes the expected result
    task automatic run_seq(input string tag, input logic [1:0] md, input logic op,
                           input int poll_d, input bit extra_req, input int exp_hold,
                           input logic exp_err);
        exp_t e;
        e.low = P_PULSE; e.hold = exp_hold; e.err = exp_err; e.tag = tag;
        expq.push_back(e);
        if (md == 2'b01) begin
            rdy_pin_i = 1'b0;
            repeat (4) @(negedge clk);
        end
        @(negedge clk);
        mode_i = md; op_busy_i = op; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        mode_i = 2'b00; op_busy_i = ~op;
        if (extra_req) begin
            repeat (3) @(negedge clk);
            req_i = 1'b1;
            @(negedge clk);
            req_i = 1'b0;
        end
        if (md == 2'b01 && poll_d >= 0) begin
            while (!flash_rst_n_o) @(negedge clk);
            repeat (poll_d) @(negedge clk);
            rdy_pin_i = 1'b1;
        end
        while (!done_o) @(negedge clk);
        rdy_pin_i = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset line", int'(flash_rst_n_o), 1);
        check("R1 hold", int'(ctl_hold_o), 0);
        check("R1 done", int'(done_o), 1);
        check("R1 err", int'(err_o), 0);
        repeat (4) @(negedge clk);

        run_seq("R3 fixed idle-op", 2'b00, 1'b0, -1, 0, P_PULSE + P_HOLD, 1'b0);
        run_seq("R4 fixed busy-op", 2'b00, 1'b1, -1, 0, imax(P_READY, P_PULSE + P_HOLD), 1'b0);
        run_seq("R5 uniform idle-op", 2'b10, 1'b0, -1, 0, P_PULSE + imax(P_HOLD, P_RPH - P_PULSE), 1'b0);
        run_seq("R5 uniform busy-op", 2'b11, 1'b1, -1, 0, P_PULSE + imax(P_HOLD, P_RPH - P_PULSE), 1'b0);
        run_seq("R6 poll d3", 2'b01, 1'b1, 3, 0, P_PULSE + 3 + 3, 1'b0);
        run_seq("R6 poll d0", 2'b01, 1'b0, 0, 0, P_PULSE + 0 + 3, 1'b0);
        run_seq("R7 poll timeout", 2'b01, 1'b1, -1, 0, P_PULSE + P_TO, 1'b1);
        repeat (10) @(negedge clk);
        check("R10 err held while idle", int'(err_o), 1);
        run_seq("R9 fixed with repeat request", 2'b00, 1'b0, -1, 1, P_PULSE + P_HOLD, 1'b0);
        check("R10 err cleared by next request", int'(err_o), 0);
        repeat (30) @(negedge clk);
        check("R9 no extra sequence: hold", int'(ctl_hold_o), 0);
        check("R9 no pending expected", expq.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule